// File: doc/BRIEF.md
# Quadrature XOR phase comparator

The block measures the phase offset between two reference clocks that run at the same frequency after prescaling. Both references are sampled by a fast system clock. Each passes through its own programmable prescaler and then a two-flop divide-by-four stage. That stage yields an in-phase square wave and a second square wave lagging it by a quarter period.

Two XOR comparators are formed from the divided signals. The direct comparator combines the in-phase outputs of both channels. The cross comparator combines the in-phase output of channel A with the lagging output of channel B. The fraction of time each comparator output is high grows in proportion to the phase offset. Because the two comparators sit a quarter period apart, one of them is always away from its folded ends.

The high time of each comparator is counted in system-clock cycles over a window of a programmable number of divided channel-A periods. At the end of each window both counts and a selection flag are latched together. The flag names the comparator whose count lies closer to half the window, which is the one in its linear range.

Top module: `phc_quad_compare`

## Requirements
- R1: Each channel's prescaler emits one step for every N rising edges of its reference, where N is the 4-bit ratio input; ratio values 0 and 1 both give N = 1 (bypass).
- R2: Each divide-by-four stage resets to in-phase = 0 and lagging = 0. On every prescaler step it advances through the sequence (in-phase, lagging) = 00, 10, 11, 01, so each output has 50% duty and the lagging output trails the in-phase output by one step (a quarter period).
- R3: `cnt_direct_o` is the number of system-clock cycles in the window during which channel A in-phase XOR channel B in-phase was high.
- R4: `cnt_cross_o` is the number of system-clock cycles in the window during which channel A in-phase XOR channel B lagging was high.
- R5: A window starts at a rising edge of channel A's in-phase output; the first such edge after reset starts the first window. A window spans W full channel-A divided periods, where W is `win_i` and 0 is treated as 1, so consecutive result pulses are exactly W divided periods apart.
- R6: At the end of each window both counts and the flag update together, with `valid_o` high for exactly one system-clock cycle. All three outputs hold their values until the next window ends.
- R7: `sel_cross_o` is 1 only when the cross count is strictly closer to half the window length than the direct count; on a tie it is 0 (direct comparator).
- R8: While `rst_ni` is low, all counts, the flag and `valid_o` are 0.
- R9: Unequal reference frequencies are measured correctly when the prescaler ratios bring both divided clocks to the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_a_i | input | 1 | Reference clock A (asynchronous, sampled) |
| ref_b_i | input | 1 | Reference clock B (asynchronous, sampled) |
| pre_a_i | input | 4 | Prescaler ratio for channel A (0 or 1 = bypass) |
| pre_b_i | input | 4 | Prescaler ratio for channel B (0 or 1 = bypass) |
| win_i | input | 8 | Window length in divided channel-A periods (0 = 1) |
| cnt_direct_o | output | 16 | High-time count of the direct comparator |
| cnt_cross_o | output | 16 | High-time count of the cross comparator |
| sel_cross_o | output | 1 | 1 = cross comparator nearer mid-scale |
| valid_o | output | 1 | One-cycle pulse when results update |

## Verification
Each result is due one system-clock cycle after the channel-A in-phase edge that closes a window. Both channels pass through identical synchronizer and divider latency, so the offset between them is preserved exactly. The monitor therefore does not count a fixed delay from stimulus. It pops one expected item per `valid_o` pulse and checks that the spacing between pulses equals exactly W times the divided period. The first window after each reset can be partial and is discarded. The bench then compares two full windows per setting and checks, just before the next reset, that the outputs still hold the last result.

// File: rtl/phc_pkg.sv
package phc_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_A   = 0;
  localparam int unsigned CH_B   = 1;

  typedef enum logic {
    SEL_DIRECT = 1'b0,
    SEL_CROSS  = 1'b1
  } sel_e;
endpackage

// File: rtl/phc_prescale.sv
module phc_prescale #(
  parameter int unsigned PRE_W  = 4,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic [PRE_W-1:0] ratio_i,
  output logic             step_o
);
  localparam int unsigned SH_W = SYNC_N + 1;

  logic [SH_W-1:0]  sh_q;
  logic [PRE_W-1:0] cnt_q;
  logic             rise;
  logic             bypass;
  logic             last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SH_W-2:0], ref_i};
  end

  assign rise   = sh_q[SH_W-2] & ~sh_q[SH_W-1];
  assign bypass = (ratio_i <= PRE_W'(1));
  assign last   = bypass || (cnt_q >= ratio_i - PRE_W'(1));
  assign step_o = rise & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (rise) cnt_q <= last ? '0 : cnt_q + PRE_W'(1);
  end

  // R1
  bypass_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && bypass) |-> step_o);
endmodule

// File: rtl/phc_quarter.sv
module phc_quarter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic ph_i_o,
  output logic ph_q_o
);
  // two-flop twisted ring: 00 -> 10 -> 11 -> 01
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_i_o <= 1'b0;
      ph_q_o <= 1'b0;
    end else if (step_i) begin
      ph_i_o <= ~ph_q_o;
      ph_q_o <= ph_i_o;
    end
  end

  // R2
  one_bit_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> $countones({ph_i_o, ph_q_o} ^ $past({ph_i_o, ph_q_o})) == 1);
  // R2
  hold_no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable({ph_i_o, ph_q_o}));
endmodule

// File: rtl/phc_duty_meter.sv
module phc_duty_meter
  import phc_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned WIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_ph_i,
  input  logic             xor_dir_i,
  input  logic             xor_crs_i,
  input  logic [WIN_W-1:0] win_i,
  output logic [CNT_W-1:0] cnt_dir_o,
  output logic [CNT_W-1:0] cnt_crs_o,
  output sel_e             sel_o,
  output logic             valid_o
);
  logic             ph_d_q;
  logic             armed_q;
  logic [WIN_W-1:0] per_q;
  logic [CNT_W-1:0] acc_dir_q, acc_crs_q, tot_q;
  logic [WIN_W-1:0] win_last;
  logic             bound, close_win, restart;
  logic [CNT_W-1:0] half, dist_dir, dist_crs;

  assign bound     = ref_ph_i & ~ph_d_q;
  assign win_last  = (win_i == '0) ? '0 : win_i - WIN_W'(1);
  assign close_win = bound && armed_q && (per_q == win_last);
  assign restart   = bound && (!armed_q || per_q == win_last);

  assign half     = tot_q >> 1;
  assign dist_dir = (acc_dir_q >= half) ? acc_dir_q - half : half - acc_dir_q;
  assign dist_crs = (acc_crs_q >= half) ? acc_crs_q - half : half - acc_crs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_d_q    <= 1'b0;
      armed_q   <= 1'b0;
      per_q     <= '0;
      acc_dir_q <= '0;
      acc_crs_q <= '0;
      tot_q     <= '0;
    end else begin
      ph_d_q <= ref_ph_i;
      if (bound) armed_q <= 1'b1;
      if (restart) begin
        per_q     <= '0;
        acc_dir_q <= CNT_W'(xor_dir_i);
        acc_crs_q <= CNT_W'(xor_crs_i);
        tot_q     <= CNT_W'(1);
      end else if (armed_q) begin
        if (bound) per_q <= per_q + WIN_W'(1);
        acc_dir_q <= acc_dir_q + CNT_W'(xor_dir_i);
        acc_crs_q <= acc_crs_q + CNT_W'(xor_crs_i);
        tot_q     <= tot_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_dir_o <= '0;
      cnt_crs_o <= '0;
      sel_o     <= SEL_DIRECT;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= close_win;
      if (close_win) begin
        cnt_dir_o <= acc_dir_q;
        cnt_crs_o <= acc_crs_q;
        sel_o     <= (dist_crs < dist_dir) ? SEL_CROSS : SEL_DIRECT;
      end
    end
  end

  // R6
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R3
  dir_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_dir_q <= tot_q);
  // R4
  crs_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_crs_q <= tot_q);
  // R6
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable({cnt_dir_o, cnt_crs_o, sel_o}) || $past(!rst_ni));
endmodule

// File: rtl/phc_quad_compare.sv
module phc_quad_compare
  import phc_pkg::*;
#(
  parameter int unsigned PRE_W  = 4,
  parameter int unsigned WIN_W  = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_a_i,
  input  logic             ref_b_i,
  input  logic [PRE_W-1:0] pre_a_i,
  input  logic [PRE_W-1:0] pre_b_i,
  input  logic [WIN_W-1:0] win_i,
  output logic [CNT_W-1:0] cnt_direct_o,
  output logic [CNT_W-1:0] cnt_cross_o,
  output logic             sel_cross_o,
  output logic             valid_o
);
  logic [NUM_CH-1:0] ref_v, step_v, ph_i_v, ph_q_v;
  logic [PRE_W-1:0]  ratio_v [NUM_CH];
  sel_e              sel;

  assign ref_v[CH_A]   = ref_a_i;
  assign ref_v[CH_B]   = ref_b_i;
  assign ratio_v[CH_A] = pre_a_i;
  assign ratio_v[CH_B] = pre_b_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    phc_prescale #(.PRE_W(PRE_W), .SYNC_N(SYNC_N)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ref_i  (ref_v[c]),
      .ratio_i(ratio_v[c]),
      .step_o (step_v[c])
    );
    phc_quarter u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (step_v[c]),
      .ph_i_o (ph_i_v[c]),
      .ph_q_o (ph_q_v[c])
    );
  end

  phc_duty_meter #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_meter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_ph_i (ph_i_v[CH_A]),
    .xor_dir_i(ph_i_v[CH_A] ^ ph_i_v[CH_B]),
    .xor_crs_i(ph_i_v[CH_A] ^ ph_q_v[CH_B]),
    .win_i    (win_i),
    .cnt_dir_o(cnt_direct_o),
    .cnt_crs_o(cnt_cross_o),
    .sel_o    (sel),
    .valid_o  (valid_o)
  );

  assign sel_cross_o = (sel == SEL_CROSS);

  // R8
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o && cnt_direct_o == '0 && cnt_cross_o == '0);
endmodule

// File: tb/phc_quad_compare_tb_top.sv
module phc_quad_compare_tb_top;
  typedef struct {
    int dir;
    int crs;
    int sel;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_a = 1'b0, ref_b = 1'b0;
  logic [3:0]  pre_a = 4'd1, pre_b = 4'd1;
  logic [7:0]  win = 8'd1;
  logic [15:0] cnt_dir, cnt_crs;
  logic        sel_crs, valid;

  int    total = 0, bad = 0;
  int    cyc = 0;
  item_t exp_q[$];
  item_t last_exp;
  bit    gen_en = 1'b0;
  int    gcnt = 0;
  int    per_a = 4, per_b = 4, dly = 0;
  int    win_len = 0;
  bit    skip_first = 1'b0;
  int    last_v = 0;
  bit    done = 1'b0;

  always #2 clk = ~clk;

  phc_quad_compare dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ref_a_i     (ref_a),
    .ref_b_i     (ref_b),
    .pre_a_i     (pre_a),
    .pre_b_i     (pre_b),
    .win_i       (win),
    .cnt_direct_o(cnt_dir),
    .cnt_cross_o (cnt_crs),
    .sel_cross_o (sel_crs),
    .valid_o     (valid)
  );

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // reference generation
  always @(negedge clk) begin
    cyc++;
    if (gen_en) begin
      ref_a <= (gcnt % per_a) < per_a / 2;
      ref_b <= (gcnt >= dly) && (((gcnt - dly) % per_b) < per_b / 2);
      gcnt++;
    end else begin
      ref_a <= 1'b0;
      ref_b <= 1'b0;
      gcnt = 0;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (skip_first) begin
        skip_first = 1'b0;
      end else if (exp_q.size() == 0) begin
        check("R6 unexpected result", 1, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check("R3 direct count", int'(cnt_dir), e.dir);
        check("R4 cross count", int'(cnt_crs), e.crs);
        check("R7 select", int'(sel_crs), e.sel);
        check("R5 window spacing", cyc - last_v, win_len);
        last_exp = e;
      end
      last_v = cyc;
    end
  end

  function automatic int eff(input int r);
    return (r <= 1) ? 1 : r;
  endfunction

  // high cycles per period of a square wave XORed with a copy delayed by d
  function automatic int xor_high(input int d, input int p);
    int m;
    m = d % p;
    return 2 * ((m < p - m) ? m : p - m);
  endfunction

  task automatic run(input int pa, input int pb, input int ra, input int rb,
                     input int d, input int w);
    int    na, nb, p, w_eff, d_i, d_q, hi_d, hi_c, half, dd, dc;
    item_t e;
    na    = eff(ra);
    nb    = eff(rb);
    p     = 4 * na * pa;
    w_eff = (w == 0) ? 1 : w;
    d_i   = d + (nb - 1) * pb - (na - 1) * pa;
    d_q   = d_i + nb * pb;
    hi_d  = xor_high(d_i, p) * w_eff;
    hi_c  = xor_high(d_q, p) * w_eff;
    half  = p * w_eff / 2;
    dd    = (hi_d > half) ? hi_d - half : half - hi_d;
    dc    = (hi_c > half) ? hi_c - half : half - hi_c;
    e.dir = hi_d;
    e.crs = hi_c;
    e.sel = (dc < dd) ? 1 : 0;

    rst_n  = 1'b0;
    gen_en = 1'b0;
    per_a  = pa;
    per_b  = pb;
    dly    = d;
    pre_a  = 4'(ra);
    pre_b  = 4'(rb);
    win    = 8'(w);
    win_len = p * w_eff;
    repeat (3) @(negedge clk);
    skip_first = 1'b1;
    exp_q.push_back(e);
    exp_q.push_back(e);
    rst_n  = 1'b1;
    gen_en = 1'b1;
    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
    // R6 outputs hold the last result
    check("R6 hold direct", int'(cnt_dir), last_exp.dir);
    check("R6 hold select", int'(sel_crs), last_exp.sel);
    gen_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 direct", int'(cnt_dir), 0);
    check("R8 cross", int'(cnt_crs), 0);
    check("R8 select", int'(sel_crs), 0);
    check("R8 valid", int'(valid), 0);
    // R3 R4 R7: sweep of offsets, bypass prescale, W=3
    run(4, 4, 1, 1, 0, 3);   // dir 0,  crs 24 -> cross
    run(4, 4, 1, 1, 1, 3);   // dir 6,  crs 30 -> cross
    run(4, 4, 1, 1, 2, 3);   // tie 12/36 -> direct (R7)
    run(4, 4, 1, 1, 3, 3);   // dir 18, crs 42 -> direct
    run(4, 4, 1, 1, 6, 3);   // tie 36/36 -> direct (R7)
    run(4, 4, 1, 1, 7, 3);   // dir 42, crs 30 -> cross
    // R1 ratio 0 acts as bypass, R5 window 0 acts as 1
    run(4, 4, 0, 0, 3, 0);
    // R1 ratio 2 on both channels
    run(4, 4, 2, 2, 3, 2);
    // R9 unequal frequencies brought to a common period
    run(8, 4, 1, 2, 1, 2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule